// File: doc/BRIEF.md
# Emulated PHY Pause Resolution and Reset Sequencer

This block models the register side of a PHY that is emulated on a switch port with no cable and no real link partner behind it. Software programs a pause advertisement. The block then builds the partner's ability by mirroring that advertisement and resolves the transmit and receive pause enables that the switch port should use. A manual flow-control register can take over the pause enables. It also reports the duplex and pause settings that are currently in force.

Three separate software request bits start one shared, timed block reset. The first sits in the basic control register, the second in a chip reset-control register and the third in a power-management register. While the reset runs, every register is held at its default and each request bit reads back as 1. When the cycle count expires, all three request bits read back as 0.

The register port is a single-cycle write with a combinational read on the same address. The serial management framing and the switch datapath are outside this block.

Top module: `vphy_fc_ctrl`

## Requirements
- R1: After `rst_n` is released, the basic control register (offset 0) reads 0x1100, meaning auto-negotiation is on (bit 12) and full duplex is selected (bit 8). The advertisement register (offset 1) reads 0x0401, meaning symmetric pause (bit 10) is set, asymmetric pause (bit 11) is clear and the selector field is 1. The manual register (offset 3) reads 0x0070, and `tx_pause_en`, `rx_pause_en` and `full_duplex` are all 1 with `phy_rst` at 0.
- R2: The partner register (offset 2) always reads bits 11:10 equal to bits 11:10 of the advertisement register, with the selector field equal to 1 and all other bits 0.
- R3: With auto-negotiation on and manual select off, both pause enables equal the advertised symmetric bit (bit 10) when full duplex is selected, whatever the asymmetric bit is. Both enables are 0 in half duplex.
- R4: When manual select (offset 3 bit 0) is 1, or auto-negotiation (offset 0 bit 12) is 0, `tx_pause_en` equals offset 3 bit 1 and `rx_pause_en` equals offset 3 bit 2.
- R5: A write to the manual register leaves the advertisement register unchanged.
- R6: A read of offset 3 returns the stored bits 2:0, and it also returns the active duplex in bit 4, the active transmit pause in bit 5 and the active receive pause in bit 6.
- R7: A write of 1 to any of three request bits starts the reset: offset 0 bit 15, offset 4 bit 3 or offset 5 bit 10. `phy_rst` rises on the clock edge that takes the write and stays high for exactly `RST_CYCLES` cycles.
- R8: While `phy_rst` is high, all registers hold their defaults and writes are ignored. After the reset ends, the registers still read their defaults.
- R9: While `phy_rst` is high, offset 0 bit 15, offset 4 bit 3 and offset 5 bit 10 read back as 1. Once it falls, they read back as 0.
- R10: A request made while a reset is running restarts the count, so `phy_rst` stays high for `RST_CYCLES` cycles after the later request.
- R11: Asserting `rst_n` during a running reset ends it at once and restores all defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware / power-on reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| tx_pause_en | output | 1 | Resolved transmit pause enable |
| rx_pause_en | output | 1 | Resolved receive pause enable |
| full_duplex | output | 1 | Active duplex, 1 = full |
| phy_rst | output | 1 | Block reset in progress |

## Verification
All register state and the reset flag are updated on the clock edge that takes a write. The pause outputs, `full_duplex` and `reg_rdata` follow from that state combinationally, so every result is due in the cycle right after the write. Each write task in the bench drives at a falling edge and returns at the next falling edge, so that one rising edge has passed before any sampling. Reads set the address at a falling edge and sample 1 ns later. The reset length is measured by counting the falling edges at which `phy_rst` is high, starting from the first one after the request edge. That count must equal `RST_CYCLES` exactly, both for a single request and for a restarted one.

// File: rtl/vphy_fc_pkg.sv
`timescale 1ns/1ps
package vphy_fc_pkg;
   // register offsets
   localparam int OFF_BASIC   = 0;
   localparam int OFF_ADV     = 1;
   localparam int OFF_PARTNER = 2;
   localparam int OFF_MANUAL  = 3;
   localparam int OFF_RSTCTL  = 4;
   localparam int OFF_PWRMGT  = 5;
   // bit positions
   localparam int BIT_BASIC_RST  = 15;
   localparam int BIT_BASIC_AN   = 12;
   localparam int BIT_BASIC_DUP  = 8;
   localparam int BIT_ADV_ASYM   = 11;
   localparam int BIT_ADV_SYM    = 10;
   localparam int BIT_RSTCTL_RST = 3;
   localparam int BIT_PWRMGT_RST = 10;

   typedef struct packed {
      logic autoneg;
      logic duplex;
      logic adv_sym;
      logic adv_asym;
      logic man_sel;
      logic man_tx;
      logic man_rx;
   } fc_state_t;

   localparam fc_state_t FC_DEFAULTS = '{autoneg: 1'b1, duplex: 1'b1,
                                         adv_sym: 1'b1, adv_asym: 1'b0,
                                         man_sel: 1'b0, man_tx: 1'b0,
                                         man_rx: 1'b0};
endpackage

// File: rtl/vphy_reset_seq.sv
`timescale 1ns/1ps
module vphy_reset_seq #(
   parameter int RST_CYCLES = 10200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy
);
   localparam int CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

   generate
      if (RST_CYCLES < 1) begin : g_bad
         $error("RST_CYCLES must be at least 1");
      end
      if (RST_CYCLES == 1) begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy <= 1'b0;
            else        busy <= req;
         end
      end else begin : g_count
         logic [CNT_W-1:0] remain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy     <= 1'b0;
               remain_q <= '0;
            end else if (req) begin
               busy     <= 1'b1;
               remain_q <= CNT_W'(RST_CYCLES - 1);
            end else if (busy) begin
               if (remain_q == '0) busy <= 1'b0;
               else                remain_q <= remain_q - 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vphy_pause_resolve.sv
`timescale 1ns/1ps
module vphy_pause_resolve #(
   parameter bit GATE_HALF_DUPLEX = 1'b1
) (
   input  logic autoneg,
   input  logic duplex,
   input  logic loc_sym,
   input  logic loc_asym,
   input  logic par_sym,
   input  logic par_asym,
   input  logic man_sel,
   input  logic man_tx,
   input  logic man_rx,
   output logic tx_en,
   output logic rx_en
);
   logic an_tx, an_rx, dup_ok, use_manual;

   // priority resolution between local and partner abilities
   assign an_tx = (loc_sym & par_sym) | (~loc_sym & loc_asym & par_sym & par_asym);
   assign an_rx = (loc_sym & par_sym) | (loc_sym & loc_asym & ~par_sym & par_asym);

   generate
      if (GATE_HALF_DUPLEX) begin : g_gate
         assign dup_ok = duplex;
      end else begin : g_nogate
         assign dup_ok = 1'b1;
      end
   endgenerate

   assign use_manual = man_sel | ~autoneg;
   assign tx_en = use_manual ? man_tx : (an_tx & dup_ok);
   assign rx_en = use_manual ? man_rx : (an_rx & dup_ok);
endmodule

// File: rtl/vphy_regfile.sv
`timescale 1ns/1ps
module vphy_regfile import vphy_fc_pkg::*; #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output fc_state_t         st
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= FC_DEFAULTS;
      end else if (clear) begin
         st <= FC_DEFAULTS;
      end else if (wr) begin
         if (addr == ADDR_W'(OFF_BASIC)) begin
            st.autoneg <= wdata[BIT_BASIC_AN];
            st.duplex  <= wdata[BIT_BASIC_DUP];
         end
         if (addr == ADDR_W'(OFF_ADV)) begin
            st.adv_sym  <= wdata[BIT_ADV_SYM];
            st.adv_asym <= wdata[BIT_ADV_ASYM];
         end
         if (addr == ADDR_W'(OFF_MANUAL)) begin
            st.man_sel <= wdata[0];
            st.man_tx  <= wdata[1];
            st.man_rx  <= wdata[2];
         end
      end
   end
endmodule

// File: rtl/vphy_fc_ctrl.sv
`timescale 1ns/1ps
module vphy_fc_ctrl import vphy_fc_pkg::*; #(
   parameter int DATA_W           = 16,
   parameter int ADDR_W           = 3,
   parameter int RST_CYCLES       = 10200,
   parameter bit GATE_HALF_DUPLEX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              tx_pause_en,
   output logic              rx_pause_en,
   output logic              full_duplex,
   output logic              phy_rst
);
   generate
      if (DATA_W < 16) begin : g_bad_dw
         $error("DATA_W must be at least 16");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W must be at least 3");
      end
   endgenerate

   fc_state_t   st;
   logic        rst_req, busy, par_sym, par_asym;
   logic [15:0] rd16;

   assign rst_req = reg_wr &
      (((reg_addr == ADDR_W'(OFF_BASIC))  & reg_wdata[BIT_BASIC_RST])  |
       ((reg_addr == ADDR_W'(OFF_RSTCTL)) & reg_wdata[BIT_RSTCTL_RST]) |
       ((reg_addr == ADDR_W'(OFF_PWRMGT)) & reg_wdata[BIT_PWRMGT_RST]));

   vphy_reset_seq #(.RST_CYCLES(RST_CYCLES)) seq_i (
      .clk(clk), .rst_n(rst_n), .req(rst_req), .busy(busy));

   vphy_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .clear(rst_req | busy), .wr(reg_wr),
      .addr(reg_addr), .wdata(reg_wdata), .st(st));

   // synthesized partner: mirrors local pause advertisement
   assign par_sym  = st.adv_sym;
   assign par_asym = st.adv_asym;

   vphy_pause_resolve #(.GATE_HALF_DUPLEX(GATE_HALF_DUPLEX)) res_i (
      .autoneg(st.autoneg), .duplex(st.duplex),
      .loc_sym(st.adv_sym), .loc_asym(st.adv_asym),
      .par_sym(par_sym), .par_asym(par_asym),
      .man_sel(st.man_sel), .man_tx(st.man_tx), .man_rx(st.man_rx),
      .tx_en(tx_pause_en), .rx_en(rx_pause_en));

   assign full_duplex = st.duplex;
   assign phy_rst     = busy;

   always_comb begin
      rd16 = '0;
      if (reg_addr == ADDR_W'(OFF_BASIC)) begin
         rd16[BIT_BASIC_RST] = busy;
         rd16[BIT_BASIC_AN]  = st.autoneg;
         rd16[BIT_BASIC_DUP] = st.duplex;
      end
      if (reg_addr == ADDR_W'(OFF_ADV)) begin
         rd16[BIT_ADV_ASYM] = st.adv_asym;
         rd16[BIT_ADV_SYM]  = st.adv_sym;
         rd16[0]            = 1'b1;
      end
      if (reg_addr == ADDR_W'(OFF_PARTNER)) begin
         rd16[BIT_ADV_ASYM] = par_asym;
         rd16[BIT_ADV_SYM]  = par_sym;
         rd16[0]            = 1'b1;
      end
      if (reg_addr == ADDR_W'(OFF_MANUAL)) begin
         rd16[0] = st.man_sel;
         rd16[1] = st.man_tx;
         rd16[2] = st.man_rx;
         rd16[4] = st.duplex;
         rd16[5] = tx_pause_en;
         rd16[6] = rx_pause_en;
      end
      if (reg_addr == ADDR_W'(OFF_RSTCTL)) rd16[BIT_RSTCTL_RST] = busy;
      if (reg_addr == ADDR_W'(OFF_PWRMGT)) rd16[BIT_PWRMGT_RST] = busy;
   end

   assign reg_rdata = DATA_W'(rd16);
endmodule

// File: rtl/vphy_fc_ctrl_chk.sv
`timescale 1ns/1ps
module vphy_fc_ctrl_chk import vphy_fc_pkg::*; #(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 3,
   parameter int RST_CYCLES = 10200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              tx_pause_en,
   input logic              rx_pause_en,
   input logic              full_duplex,
   input logic              phy_rst,
   input logic [1:0]        adv_bits
);
   localparam int CW = $clog2(RST_CYCLES + 1) + 1;

   logic          req_seen;
   logic [CW-1:0] run_cnt;

   assign req_seen = reg_wr &
      (((reg_addr == ADDR_W'(OFF_BASIC))  & reg_wdata[BIT_BASIC_RST])  |
       ((reg_addr == ADDR_W'(OFF_RSTCTL)) & reg_wdata[BIT_RSTCTL_RST]) |
       ((reg_addr == ADDR_W'(OFF_PWRMGT)) & reg_wdata[BIT_PWRMGT_RST]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_cnt <= '0;
      else if (req_seen) run_cnt <= '0;
      else if (phy_rst)  run_cnt <= run_cnt + 1'b1;
      else               run_cnt <= '0;
   end

   // R7: a request raises the reset on the next cycle
   assert_rst_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_seen |=> phy_rst);
   // R7 / R10: reset never outlasts RST_CYCLES since the last request
   assert_rst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rst |-> (run_cnt < CW'(RST_CYCLES)));
   // R8: defaults in force during reset
   assert_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rst |-> (tx_pause_en && rx_pause_en && full_duplex));
   // R9: request bit reads back the reset state
   assert_rst_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFF_BASIC)) |-> (reg_rdata[BIT_BASIC_RST] == phy_rst));
   // R2: partner mirrors advertisement
   assert_partner_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFF_PARTNER)) |-> (reg_rdata[11:10] == adv_bits));
   // R5: manual writes leave the advertisement alone
   assert_adv_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFF_MANUAL)) |=> $stable(adv_bits));
endmodule

bind vphy_fc_ctrl vphy_fc_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                                     .RST_CYCLES(RST_CYCLES)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pause_en(tx_pause_en),
   .rx_pause_en(rx_pause_en), .full_duplex(full_duplex), .phy_rst(phy_rst),
   .adv_bits({st.adv_asym, st.adv_sym}));

// File: tb/vphy_fc_ctrl_tb_top.sv
`timescale 1ns/1ps
module vphy_fc_ctrl_tb_top;
   localparam int DW  = 16;
   localparam int AW  = 3;
   localparam int RST = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          tx_pause_en, rx_pause_en, full_duplex, phy_rst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vphy_fc_ctrl #(.DATA_W(DW), .ADDR_W(AW), .RST_CYCLES(RST)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pause_en(tx_pause_en),
      .rx_pause_en(rx_pause_en), .full_duplex(full_duplex), .phy_rst(phy_rst));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = AW'(a);
      #1 d = reg_rdata;
   endtask

   task automatic chk_out(input string tag, input logic tx, input logic rx);
      chk({tag, " tx"}, 32'(tx_pause_en), 32'(tx));
      chk({tag, " rx"}, 32'(rx_pause_en), 32'(rx));
   endtask

   task automatic chk_defaults(input string tag);
      logic [15:0] d;
      rd(0, d); chk({tag, " basic"}, 32'(d), 32'h1100);
      rd(1, d); chk({tag, " adv"}, 32'(d), 32'h0401);
      rd(3, d); chk({tag, " manual"}, 32'(d), 32'h0070);
      chk_out(tag, 1'b1, 1'b1);
      chk({tag, " duplex"}, 32'(full_duplex), 32'd1);
   endtask

   task automatic wait_rst(output int n);
      n = 0;
      while (phy_rst === 1'b1 && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_defaults;
      chk_defaults("R1");
      chk("R1 phy_rst", 32'(phy_rst), 32'd0);
   endtask

   task automatic t_partner;
      logic [15:0] d;
      wr(1, 16'h0801); rd(2, d); chk("R2 partner asym", 32'(d), 32'h0801);
      wr(1, 16'h0C01); rd(2, d); chk("R2 partner both", 32'(d), 32'h0C01);
      wr(1, 16'h0001); rd(2, d); chk("R2 partner none", 32'(d), 32'h0001);
   endtask

   task automatic t_an_resolve;
      wr(0, 16'h1100);
      wr(1, 16'h0401); chk_out("R3 sym", 1'b1, 1'b1);
      wr(1, 16'h0801); chk_out("R3 asym only", 1'b0, 1'b0);
      wr(1, 16'h0C01); chk_out("R3 sym+asym", 1'b1, 1'b1);
      wr(1, 16'h0001); chk_out("R3 none", 1'b0, 1'b0);
      wr(1, 16'h0401); wr(0, 16'h1000);
      chk_out("R3 half duplex", 1'b0, 1'b0);
      chk("R3 duplex out", 32'(full_duplex), 32'd0);
      wr(0, 16'h1100);
   endtask

   task automatic t_manual;
      logic [15:0] d;
      wr(1, 16'h0801);
      wr(3, 16'h0003); chk_out("R4 sel tx", 1'b1, 1'b0);
      wr(3, 16'h0005); chk_out("R4 sel rx", 1'b0, 1'b1);
      rd(3, d); chk("R6 manual status", 32'(d), 32'h0055);
      rd(1, d); chk("R5 adv kept", 32'(d), 32'h0801);
      wr(3, 16'h0004); wr(0, 16'h0100);
      chk_out("R4 an off", 1'b0, 1'b1);
      wr(0, 16'h0000);
      rd(3, d); chk("R6 half status", 32'(d), 32'h0044);
      rd(1, d); chk("R5 adv kept 2", 32'(d), 32'h0801);
   endtask

   task automatic t_reset_src(input string tag, input int a, input logic [15:0] d);
      logic [15:0] v;
      int n;
      wr(1, 16'h0801); wr(3, 16'h0003); wr(0, 16'h0100);
      wr(a, d);
      chk({tag, " R7 rst high"}, 32'(phy_rst), 32'd1);
      chk_out({tag, " R8 in reset"}, 1'b1, 1'b1);
      rd(0, v); chk({tag, " R9 basic bit"}, 32'(v[15]), 32'd1);
      rd(4, v); chk({tag, " R9 rstctl bit"}, 32'(v), 32'h0008);
      rd(5, v); chk({tag, " R9 pwrmgt bit"}, 32'(v), 32'h0400);
      wr(1, 16'h0801);
      rd(1, v); chk({tag, " R8 write ignored"}, 32'(v), 32'h0401);
      wait_rst(n);
      chk({tag, " R7 ended"}, 32'(phy_rst), 32'd0);
      rd(0, v); chk({tag, " R9 basic clear"}, 32'(v), 32'h1100);
      rd(4, v); chk({tag, " R9 rstctl clear"}, 32'(v), 32'h0000);
      rd(5, v); chk({tag, " R9 pwrmgt clear"}, 32'(v), 32'h0000);
      chk_defaults({tag, " R8 after"});
   endtask

   task automatic t_reset_len;
      int n;
      wr(4, 16'h0008);
      wait_rst(n);
      chk("R7 length", 32'(n), 32'(RST));
   endtask

   task automatic t_restart;
      int n;
      wr(5, 16'h0400);
      repeat (5) @(negedge clk);
      wr(4, 16'h0008);
      wait_rst(n);
      chk("R10 restart length", 32'(n), 32'(RST));
   endtask

   task automatic t_hw_reset;
      wr(0, 16'h8000);
      chk("R11 rst running", 32'(phy_rst), 32'd1);
      @(negedge clk); rst_n = 1'b0;
      #1 chk("R11 rst aborted", 32'(phy_rst), 32'd0);
      repeat (2) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R11 still low", 32'(phy_rst), 32'd0);
      chk_defaults("R11");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_defaults();
      t_partner();
      t_an_resolve();
      t_manual();
      t_reset_src("basic", 0, 16'h8000);
      t_reset_src("rstctl", 4, 16'h0008);
      t_reset_src("pwrmgt", 5, 16'h0400);
      t_reset_len();
      t_restart();
      t_hw_reset();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule